// File: doc/BRIEF.md
# Paged edge-interrupt GPIO controller

This block gives a host 48 general-purpose lines through a byte-wide register window of 16 addresses. The lines form six ports of eight. Each port has a data register: a written 1 pulls the matching line low (open-drain style), and a read returns the synchronized levels seen on the pins. A line used as an input must keep its drive bit at 0.

The lowest 24 lines (ports 0, 1 and 2) can raise edge-triggered interrupts. Each such line has an enable bit, a polarity bit and a latched event bit. The three banks share three addresses. A page register picks which bank those addresses reach. A pending register summarises which interrupt ports hold events, and a single level output requests service. Software acknowledges an event by writing its enable bit to 0 and then back to 1. This clears the event and re-arms the line.

Top module: `edge_gpio_ctrl`

## Requirements
- R1: After reset all drive bits, enable bits, polarity bits, event bits and the page register are 0, `irq_req` is low and `bus_rdata` is 0.
- R2: A write to offset p (0..5) sets `pin_pull_low[8p+7:8p]` to the written byte, with bit n driving line 8p+n and 1 meaning pull low.
- R3: A read of offset p (0..5) returns the levels of lines 8p+7..8p after a two-flop synchronizer. `bus_rdata` takes the value on the clock edge where `bus_rd` is sampled high and holds it until the next read.
- R4: Offset 7 is the page register and reads back what was written. Page 0x80 maps the enable bytes of ports 0..2 to offsets 8..10. Page 0x40 maps the polarity bytes there. Any other page value maps the event bytes there.
- R5: An enabled line latches an event on a rising synchronized edge when its polarity bit is 1, and on a falling edge when it is 0. A line whose enable bit is 0 never latches an event.
- R6: A latched event stays set until its enable bit is written 0. Writing the enable byte with the bit cleared and then with it set clears only that event and re-arms the line.
- R7: Offset 6 reads back the pending register. Bit g (g = 0..2) is the OR of the event bits of port g, and bits 7:3 read 0. `irq_req` is high exactly when any pending bit is 1.
- R8: Writes to offsets 8..10 while the event page is selected, whether by 0xC0 or by any other non-0x40/0x80 value, change no enable or polarity bit and no event bit.
- R9: Offsets 11..15 read 0, and edges on lines 24..47 never change the pending register.
- R10: With all three enable bytes at 0, no pin activity raises `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 48 | Pin levels (asynchronous) |
| pin_pull_low | output | 48 | 1 pulls the line low |
| irq_req | output | 1 | Active-high interrupt level |

## Verification
The assertions check several rules on every cycle. An event bit is never set while its enable is 0. Events never clear except through an enable write. A new event appears only where the selected edge occurred on an enabled line. A write on the event page leaves the enable and polarity banks unchanged. The interrupt output never rises while every enable is 0. The bench scenarios cover the rest: the bank routing through each page value, the acknowledge sequence clearing a single event while others stay pending, the polarity choice per line, the read-back of pins through the synchronizer, and the lack of interrupt logic on the upper ports.

// File: rtl/egpio_pkg.sv
// Package: shared offsets, page codes and bank decode for the GPIO controller.
// Assumes a 16-byte window; offsets 6..10 are behaviour the host software relies on.
package egpio_pkg;

    localparam int PEND_OFF  = 6;
    localparam int PAGE_OFF  = 7;
    localparam int BANK_BASE = 8;

    localparam logic [7:0] PAGE_ENABLE   = 8'h80;
    localparam logic [7:0] PAGE_POLARITY = 8'h40;

    typedef enum logic [1:0] {
        BANK_EVENT    = 2'd0,
        BANK_ENABLE   = 2'd1,
        BANK_POLARITY = 2'd2
    } bank_e;

    // Map a page value to the bank seen at offsets 8..10; unknown codes act as the event page.
    function automatic bank_e decode_bank(input logic [7:0] page);
        if (page == PAGE_ENABLE)        return BANK_ENABLE;
        else if (page == PAGE_POLARITY) return BANK_POLARITY;
        else                            return BANK_EVENT;
    endfunction

endpackage

// File: rtl/egpio_sync.sv
// Module: two-flop synchronizer for a bus of independent asynchronous lines.
// Assumes every bit is sampled on its own; no cross-bit coherence is promised.
module egpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/egpio_irq_port.sv
// Module: interrupt logic for one 8-line port: enable, polarity and latched event bits.
// Assumes the level input is already synchronized. A cleared enable wipes its event in
// the same cycle, which gives the clear-then-set acknowledge sequence.
module egpio_irq_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic         en_wr,
    input  logic         pol_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] evt_q
);

    logic [W-1:0] prev_q;
    logic [W-1:0] edge_hit;
    logic [W-1:0] en_next;

    // Select rising or falling edge per line from the polarity bit.
    always_comb begin
        edge_hit = (pol_q & level & ~prev_q) | (~pol_q & ~level & prev_q);
        en_next  = en_wr ? wdata : en_q;
    end

    // Hold control bits, remember the last level, latch and clear events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pol_q  <= '0;
            evt_q  <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= level;
            if (en_wr)  en_q  <= wdata;
            if (pol_wr) pol_q <= wdata;
            evt_q <= (evt_q | (edge_hit & en_q)) & en_next;
        end
    end

    AST_EVT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & ~en_q) == '0));  // R5

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> ((evt_q & $past(evt_q)) == $past(evt_q)));  // R6

    AST_EVT_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_q & ~$past(evt_q) & ~($past(edge_hit) & $past(en_q))) == '0));  // R5

endmodule

// File: rtl/edge_gpio_ctrl.sv
// Module: top of the paged edge-interrupt GPIO controller.
// Holds port drive registers, the page register, the read mux and the interrupt summary.
// Assumes single-cycle bus strobes; read data is registered on the read strobe.
module edge_gpio_ctrl
    import egpio_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int PORT_W    = 8,
    parameter int IRQ_PORTS = 3,
    parameter int ADDR_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [PORT_W-1:0]           bus_wdata,
    output logic [PORT_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
    output logic [NUM_PORTS*PORT_W-1:0] pin_pull_low,
    output logic                        irq_req
);

    localparam int LINES     = NUM_PORTS * PORT_W;
    localparam int IRQ_LINES = IRQ_PORTS * PORT_W;

    logic [LINES-1:0]     pin_sync;
    logic [PORT_W-1:0]    page_q;
    bank_e                bank;
    logic [IRQ_LINES-1:0] en_all;
    logic [IRQ_LINES-1:0] pol_all;
    logic [IRQ_LINES-1:0] evt_all;
    logic [IRQ_PORTS-1:0] pending;
    logic [PORT_W-1:0]    rd_mux;
    logic                 bank_addr_hit;

    egpio_sync #(.W(LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PORTS; gp++) begin : g_drive
            logic [PORT_W-1:0] drive_q;
            // Load this port's drive byte on a write to its offset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    drive_q <= '0;
                else if (bus_wr && bus_addr == ADDR_W'(gp))
                    drive_q <= bus_wdata;
            end
            assign pin_pull_low[gp*PORT_W +: PORT_W] = drive_q;
        end
    endgenerate

    // Page register that selects the bank behind offsets 8..10.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= '0;
        else if (bus_wr && bus_addr == ADDR_W'(PAGE_OFF))
            page_q <= bus_wdata;
    end

    assign bank = decode_bank(page_q);

    genvar gi;
    generate
        for (gi = 0; gi < IRQ_PORTS; gi++) begin : g_irq
            logic addr_hit;
            assign addr_hit = bus_wr && (bus_addr == ADDR_W'(BANK_BASE + gi));
            egpio_irq_port #(.W(PORT_W)) u_port (
                .clk    (clk),
                .rst_n  (rst_n),
                .level  (pin_sync[gi*PORT_W +: PORT_W]),
                .en_wr  (addr_hit && bank == BANK_ENABLE),
                .pol_wr (addr_hit && bank == BANK_POLARITY),
                .wdata  (bus_wdata),
                .en_q   (en_all[gi*PORT_W +: PORT_W]),
                .pol_q  (pol_all[gi*PORT_W +: PORT_W]),
                .evt_q  (evt_all[gi*PORT_W +: PORT_W])
            );
            assign pending[gi] = |evt_all[gi*PORT_W +: PORT_W];
        end
    endgenerate

    assign irq_req = |pending;

    // Select the byte a read at bus_addr returns.
    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (bus_addr == ADDR_W'(p))
                rd_mux = pin_sync[p*PORT_W +: PORT_W];
        if (bus_addr == ADDR_W'(PEND_OFF))
            rd_mux = PORT_W'(pending);
        if (bus_addr == ADDR_W'(PAGE_OFF))
            rd_mux = page_q;
        for (int g = 0; g < IRQ_PORTS; g++)
            if (bus_addr == ADDR_W'(BANK_BASE + g)) begin
                case (bank)
                    BANK_ENABLE:   rd_mux = en_all[g*PORT_W +: PORT_W];
                    BANK_POLARITY: rd_mux = pol_all[g*PORT_W +: PORT_W];
                    default:       rd_mux = evt_all[g*PORT_W +: PORT_W];
                endcase
            end
    end

    // Register the read data on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    assign bank_addr_hit = (bus_addr >= ADDR_W'(BANK_BASE)) &&
                           (bus_addr <  ADDR_W'(BANK_BASE + IRQ_PORTS));

    AST_EVT_PAGE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bank_addr_hit && bank == BANK_EVENT) |=> ($stable(en_all) && $stable(pol_all)));  // R8

    AST_NO_IRQ_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (|en_all));  // R10

endmodule

// File: tb/edge_gpio_ctrl_test.sv
// Bench: scoreboard style. The read task queues the expected byte and the monitor
// compares it in the cycle after the registered read data appears.
module edge_gpio_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] pin_in = '0;
    logic [47:0] pin_pull_low;
    logic        irq_req;

    int tests = 0;
    int fails = 0;
    logic rd_d = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    edge_gpio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_pull_low(pin_pull_low), .irq_req(irq_req)
    );

    // Monitor: compare queued expectations once registered read data is valid.
    always @(posedge clk) rd_d <= bus_rd;
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            tests++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s: read got %02h expected %02h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk(input logic [47:0] act, input logic [47:0] e, input string t);
        tests++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: got %h expected %h", t, act, e);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({47'b0, irq_req}, 48'h0, "R1 irq after reset");
        chk(pin_pull_low, 48'h0, "R1 drive after reset");
        chk({40'b0, bus_rdata}, 48'h0, "R1 rdata after reset");
        rd(4'd7, 8'h00, "R1 page reset");
        rd(4'd6, 8'h00, "R1 pending reset");
        wr(4'd7, 8'h80);
        rd(4'd8, 8'h00, "R1 enable reset");

        // R2 drive registers
        wr(4'd0, 8'hA5);
        wr(4'd5, 8'h3C);
        chk(pin_pull_low, 48'h3C00_0000_00A5, "R2 drive ports 0 and 5");
        wr(4'd3, 8'h81);
        chk(pin_pull_low, 48'h3C00_8100_00A5, "R2 drive port 3");

        // R3 pin read-back
        pin_in = 48'h6655_4433_2211;
        settle();
        rd(4'd0, 8'h11, "R3 port0");
        rd(4'd2, 8'h33, "R3 port2");
        rd(4'd4, 8'h55, "R3 port4");
        rd(4'd5, 8'h66, "R3 port5");
        pin_in = '0;
        settle();
        rd(4'd1, 8'h00, "R3 port1 low");

        // R4 page routing
        wr(4'd7, 8'h80);
        wr(4'd8, 8'h0F);
        rd(4'd8, 8'h0F, "R4 enable bank");
        rd(4'd7, 8'h80, "R4 page readback");
        wr(4'd7, 8'h40);
        wr(4'd8, 8'h01);
        rd(4'd8, 8'h01, "R4 polarity bank");
        wr(4'd9, 8'hF0);
        wr(4'd7, 8'h80);
        rd(4'd9, 8'h00, "R4 enable port1 untouched");
        wr(4'd7, 8'h40);
        wr(4'd9, 8'h00);

        // R5 edges: bit0 rising (pol 1), bit1 falling (pol 0), bit4 disabled
        wr(4'd7, 8'hC0);
        pin_in[0] = 1'b1;
        pin_in[1] = 1'b1;
        pin_in[4] = 1'b1;
        settle();
        rd(4'd8, 8'h01, "R5 rising latched, falling-only and disabled ignored");
        rd(4'd6, 8'h01, "R7 pending port0");
        chk({47'b0, irq_req}, 48'h1, "R7 irq high");
        pin_in[1] = 1'b0;
        pin_in[4] = 1'b0;
        settle();
        rd(4'd8, 8'h03, "R5 falling edge latched");

        // R6 sticky and acknowledge
        pin_in[0] = 1'b0;
        settle();
        rd(4'd8, 8'h03, "R6 event sticky");
        wr(4'd7, 8'h80);
        wr(4'd8, 8'h0E);
        wr(4'd8, 8'h0F);
        wr(4'd7, 8'hC0);
        rd(4'd8, 8'h02, "R6 ack clears one event");
        chk({47'b0, irq_req}, 48'h1, "R6 irq still high");
        pin_in[0] = 1'b1;
        settle();
        rd(4'd8, 8'h03, "R6 line re-armed");

        // R8 writes on event page ignored
        wr(4'd8, 8'h00);
        rd(4'd8, 8'h03, "R8 event write ignored");
        wr(4'd7, 8'h80);
        rd(4'd8, 8'h0F, "R8 enable unchanged");
        wr(4'd7, 8'h11);
        wr(4'd9, 8'hFF);
        rd(4'd8, 8'h03, "R8 odd page reads events");
        wr(4'd7, 8'h80);
        rd(4'd9, 8'h00, "R8 odd page write ignored");

        // R10 all enables off
        wr(4'd8, 8'h00);
        wr(4'd9, 8'h00);
        wr(4'd10, 8'h00);
        rd(4'd6, 8'h00, "R10 pending clear");
        pin_in[0] = 1'b0;
        pin_in[1] = 1'b1;
        pin_in[12] = 1'b1;
        settle();
        chk({47'b0, irq_req}, 48'h0, "R10 no irq while disabled");

        // R7/R9 port2 and upper ports
        wr(4'd7, 8'h40);
        wr(4'd10, 8'h80);
        wr(4'd7, 8'h80);
        wr(4'd10, 8'h80);
        pin_in[23] = 1'b1;
        settle();
        rd(4'd6, 8'h04, "R7 pending port2");
        wr(4'd7, 8'hC0);
        rd(4'd10, 8'h80, "R7 port2 event");
        pin_in[30] = 1'b1;
        pin_in[47] = 1'b1;
        settle();
        rd(4'd6, 8'h04, "R9 upper ports no events");
        rd(4'd11, 8'h00, "R9 offset 11");
        rd(4'd15, 8'h00, "R9 offset 15");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule